// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources behind a small word-addressed register bus. Software picks which sources are enabled and whether each enabled source raises the normal request or the fast request. The pending state can be read in three forms: the raw source levels, the enabled sources routed to the normal request, and the enabled sources routed to the fast request. Each form is combinational from the source pins, so a bit clears as soon as its peripheral drops the line.

A table of priority slots, loaded by software, ranks the sources. Each slot names one source and carries its own valid flag. The lowest-numbered valid slot whose source is a pending, enabled, normal-routed interrupt wins. The winner is registered once per clock and can be read from the highest-priority register, with a valid flag above it. A wake output tells an idle processor that work is waiting. One control bit chooses whether only enabled sources wake it or any raw level does.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Word registers sit at byte offsets 0x00 normal pending, 0x04 enable mask, 0x08 route select, 0x0C fast pending, 0x10 raw levels, 0x14 control and 0x18 highest-priority. Slot k is at 0x1C + 4*k. An address with bit 1 or bit 0 set selects nothing and reads 0.
- R2: In the mask, bit n = 1 enables source n. A source whose mask bit is 0 never appears in the normal or the fast pending view.
- R3: In the route register, bit n = 0 sends enabled source n to the normal view. Bit n = 1 sends it to the fast view.
- R4: A slot register holds a source number in bits 4:0 and a valid flag in bit 31. Every other bit reads 0. A slot with bit 31 clear never takes part in resolution.
- R5: The highest-priority register reads bit 31 = 1 and the winning source number in bits 30:16 when the lowest-numbered valid slot names a pending normal-view source. Otherwise it reads 0. It reflects the inputs as of the previous clock edge.
- R6: With control bit 0 = 1, `wake` rises one clock after any enabled source is pending. With control bit 0 = 0, it rises one clock after any raw level is high.
- R7: The raw register at 0x10 reads back the `src_lvl` pins directly. The pending views follow the pins without any latching.
- R8: After reset, the mask, route and control registers read 0, every slot reads 0 (invalid), and the highest-priority register and all three outputs are 0.
- R9: `irq_norm` is the registered OR of the normal view, and `irq_fast` is the registered OR of the fast view. Each changes one clock after its view changes.
- R10: Writes to 0x00, 0x0C, 0x10 and 0x18 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| src_lvl | input | NUM_SRC | Level-sensitive source inputs |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |
| wake | output | 1 | Idle wake request |

## Verification
The hardest case to reach is the one where the highest-priority result has to skip a candidate. This happens when a valid slot points at a source that is pending but has been routed to the fast output or masked off. A lower-priority slot must then win, or nothing must win at all. The bench loads a few slots with chosen source numbers and leaves one slot deliberately invalid. It also places a valid entry in the last slot. It then flips route and mask bits while several sources are held high. Each step shows whether the resolver follows the slot order, the valid flags and the normal-view qualification.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int HP_FIELD_LSB = 16;
  localparam int HP_FIELD_W = 15;
  localparam int VALID_BIT = 31;

  localparam logic [ADDR_W-1:0] OFS_NPEND = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ROUTE = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_FPEND = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_HP    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_SLOT0 = 8'h1C;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_NPEND, SEL_MASK, SEL_ROUTE, SEL_FPEND,
    SEL_RAW, SEL_CTRL, SEL_HP, SEL_SLOT
  } reg_sel_e;

  // Build the highest-priority readback word from its two fields.
  function automatic logic [DATA_W-1:0] hp_word(input logic valid,
                                                input logic [HP_FIELD_W-1:0] src);
    logic [DATA_W-1:0] w;
    w = '0;
    w[VALID_BIT] = valid;
    w[HP_FIELD_LSB +: HP_FIELD_W] = valid ? src : '0;
    return w;
  endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 32,
  localparam int SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_sel,
  input  logic                              bus_wr,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [DATA_W-1:0]                 bus_wdata,
  output logic [DATA_W-1:0]                 bus_rdata,
  input  logic [NUM_SRC-1:0]                src_lvl,
  input  logic [DATA_W-1:0]                 hp_rd,
  output logic [NUM_SRC-1:0]                mask_q,
  output logic                              wake_sel_q,
  output logic [NUM_SRC-1:0]                pend_norm,
  output logic [NUM_SRC-1:0]                pend_fast,
  output logic [NUM_SLOTS-1:0]              slot_valid,
  output logic [NUM_SLOTS-1:0][SRC_W-1:0]   slot_src
);
  localparam int SLOT_IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SRC-1:0] route_q;
  reg_sel_e           sel;
  logic [SLOT_IW-1:0] slot_idx;
  logic               wr_en;

  // Decode a byte address into a register selector and slot index.
  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] rel;
    if (a[1:0] != 2'b00) return SEL_NONE;
    case (a)
      OFS_NPEND: return SEL_NPEND;
      OFS_MASK:  return SEL_MASK;
      OFS_ROUTE: return SEL_ROUTE;
      OFS_FPEND: return SEL_FPEND;
      OFS_RAW:   return SEL_RAW;
      OFS_CTRL:  return SEL_CTRL;
      OFS_HP:    return SEL_HP;
      default: begin
        if (a < OFS_SLOT0) return SEL_NONE;
        rel = a - OFS_SLOT0;
        if (int'(rel >> 2) < NUM_SLOTS) return SEL_SLOT;
        return SEL_NONE;
      end
    endcase
  endfunction

  function automatic logic [SLOT_IW-1:0] slot_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] rel;
    rel = (a - OFS_SLOT0) >> 2;
    return rel[SLOT_IW-1:0];
  endfunction

  assign sel      = decode(bus_addr);
  assign slot_idx = slot_of(bus_addr);
  assign wr_en    = bus_sel && bus_wr;

  // Pending views: combinational from the level inputs.
  assign pend_norm = src_lvl & mask_q & ~route_q;
  assign pend_fast = src_lvl & mask_q & route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      route_q    <= '0;
      wake_sel_q <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        SEL_MASK:  mask_q     <= bus_wdata[NUM_SRC-1:0];
        SEL_ROUTE: route_q    <= bus_wdata[NUM_SRC-1:0];
        SEL_CTRL:  wake_sel_q <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  // One storage element pair per priority slot.
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic hit_k;
    assign hit_k = wr_en && (sel == SEL_SLOT) && (int'(slot_idx) == k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_valid[k] <= 1'b0;
        slot_src[k]   <= '0;
      end else if (hit_k) begin
        slot_valid[k] <= bus_wdata[VALID_BIT];
        slot_src[k]   <= bus_wdata[SRC_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_NPEND: bus_rdata[NUM_SRC-1:0] = pend_norm;
      SEL_MASK:  bus_rdata[NUM_SRC-1:0] = mask_q;
      SEL_ROUTE: bus_rdata[NUM_SRC-1:0] = route_q;
      SEL_FPEND: bus_rdata[NUM_SRC-1:0] = pend_fast;
      SEL_RAW:   bus_rdata[NUM_SRC-1:0] = src_lvl;
      SEL_CTRL:  bus_rdata[0] = wake_sel_q;
      SEL_HP:    bus_rdata = hp_rd;
      SEL_SLOT: begin
        bus_rdata[VALID_BIT] = slot_valid[slot_idx];
        bus_rdata[SRC_W-1:0] = slot_src[slot_idx];
      end
      default: bus_rdata = '0;
    endcase
  end

  // R2 / R3: the two views never share a bit and never show a masked source.
  a_r3_views_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_norm & pend_fast) == '0);
  a_r2_masked_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_norm | pend_fast) & ~mask_q) == '0);
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 32,
  localparam int SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              pend_norm,
  input  logic [NUM_SLOTS-1:0]            slot_valid,
  input  logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_src,
  output logic [DATA_W-1:0]               hp_rd
);
  logic [NUM_SLOTS-1:0] slot_hit;
  logic                 win_any;
  logic [SRC_W-1:0]     win_src;
  logic                 hp_valid_q;
  logic [SRC_W-1:0]     hp_src_q;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_hit
    assign slot_hit[k] = slot_valid[k] && (int'(slot_src[k]) < NUM_SRC)
                         && pend_norm[slot_src[k]];
  end

  // Lowest-numbered hitting slot wins: scan downward, last write stands.
  always_comb begin
    win_any = 1'b0;
    win_src = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (slot_hit[k]) begin
        win_any = 1'b1;
        win_src = slot_src[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_valid_q <= 1'b0;
      hp_src_q   <= '0;
    end else begin
      hp_valid_q <= win_any;
      hp_src_q   <= win_src;
    end
  end

  assign hp_rd = hp_word(hp_valid_q, HP_FIELD_W'(hp_src_q));

  // R5: a reported winner was a pending normal source one clock earlier.
  a_r5_winner_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
    hp_valid_q |-> ((($past(pend_norm) >> hp_src_q) & NUM_SRC'(1)) == NUM_SRC'(1)));
  // R4: with no valid slot nothing is reported on the next clock.
  a_r4_no_slot_no_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid == '0) |=> !hp_valid_q);
endmodule

// File: rtl/pic_outs.sv
module pic_outs #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic               wake_sel_q,
  input  logic [NUM_SRC-1:0] pend_norm,
  input  logic [NUM_SRC-1:0] pend_fast,
  output logic               irq_norm,
  output logic               irq_fast,
  output logic               wake
);
  logic wake_cause;

  // Wake source choice: enabled pending only, or any raw level.
  assign wake_cause = wake_sel_q ? |(src_lvl & mask_q) : |src_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_norm <= 1'b0;
      irq_fast <= 1'b0;
      wake     <= 1'b0;
    end else begin
      irq_norm <= |pend_norm;
      irq_fast <= |pend_fast;
      wake     <= wake_cause;
    end
  end

  a_r9_norm_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_norm) |=> irq_norm);
  a_r9_fast_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_fast == '0) |=> !irq_fast);
  a_r6_wake_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_sel_q && ((src_lvl & mask_q) == '0)) |=> !wake);
  a_r6_wake_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_sel_q && (src_lvl != '0)) |=> wake);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_lvl,
  output logic               irq_norm,
  output logic               irq_fast,
  output logic               wake
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0]              mask_q;
  logic                            wake_sel_q;
  logic [NUM_SRC-1:0]              pend_norm;
  logic [NUM_SRC-1:0]              pend_fast;
  logic [NUM_SLOTS-1:0]            slot_valid;
  logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_src;
  logic [DATA_W-1:0]               hp_rd;

  pic_regs #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .src_lvl    (src_lvl),
    .hp_rd      (hp_rd),
    .mask_q     (mask_q),
    .wake_sel_q (wake_sel_q),
    .pend_norm  (pend_norm),
    .pend_fast  (pend_fast),
    .slot_valid (slot_valid),
    .slot_src   (slot_src)
  );

  pic_resolver #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS)) u_resolver (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_norm  (pend_norm),
    .slot_valid (slot_valid),
    .slot_src   (slot_src),
    .hp_rd      (hp_rd)
  );

  pic_outs #(.NUM_SRC(NUM_SRC)) u_outs (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_lvl    (src_lvl),
    .mask_q     (mask_q),
    .wake_sel_q (wake_sel_q),
    .pend_norm  (pend_norm),
    .pend_fast  (pend_fast),
    .irq_norm   (irq_norm),
    .irq_fast   (irq_fast),
    .wake       (wake)
  );

  // R7: the raw register read returns the pins unchanged.
  a_r7_raw_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h10) |-> (bus_rdata[NUM_SRC-1:0] == src_lvl));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_lvl = '0;
  logic        irq_norm, irq_fast, wake;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_lvl(src_lvl), .irq_norm(irq_norm), .irq_fast(irq_fast), .wake(wake)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] mask;
    logic [31:0] route;
    logic        ctrl;
    logic [31:0] np;
    logic [31:0] fp;
    logic        wk;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_00F0, 32'h0000_0030, 32'h0000_0020, 1'b1, 32'h0000_0010, 32'h0000_0020, 1'b1},
    '{32'h8000_0001, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0},
    '{32'h8000_0001, 32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 32'h0000_0000, 1'b1},
    '{32'hFFFF_FFFF, 32'hFFFF_0000, 32'hFF00_0000, 1'b1, 32'h00FF_0000, 32'hFF00_0000, 1'b1},
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0},
    '{32'h0000_0100, 32'h0000_0100, 32'h0000_0100, 1'b0, 32'h0000_0000, 32'h0000_0100, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // Apply source levels, then let one clock edge register the outputs.
  task automatic drive_src(input logic [31:0] s);
    src_lvl = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    rd(8'h04, d); chk("R8 mask reset", d, 32'h0);
    rd(8'h08, d); chk("R8 route reset", d, 32'h0);
    rd(8'h14, d); chk("R8 ctrl reset", d, 32'h0);
    rd(8'h1C, d); chk("R8 slot0 reset", d, 32'h0);
    rd(8'h98, d); chk("R8 slot31 reset", d, 32'h0);
    rd(8'h18, d); chk("R8 hp reset", d, 32'h0);
    chk("R8 outputs reset", {29'h0, irq_norm, irq_fast, wake}, 32'h0);

    // R4: every slot invalid, so all-pending still reports nothing
    wr(8'h04, 32'hFFFF_FFFF);
    drive_src(32'hFFFF_FFFF);
    rd(8'h18, d); chk("R4 no valid slot", d, 32'h0);
    chk("R9 norm with all pending", {31'h0, irq_norm}, 32'h1);

    // Vector table: R2 R3 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      wr(8'h04, VECS[i].mask);
      wr(8'h08, VECS[i].route);
      wr(8'h14, {31'h0, VECS[i].ctrl});
      drive_src(VECS[i].src);
      rd(8'h00, d); chk($sformatf("R2 normal view v%0d", i), d, VECS[i].np);
      rd(8'h0C, d); chk($sformatf("R3 fast view v%0d", i), d, VECS[i].fp);
      rd(8'h10, d); chk($sformatf("R7 raw v%0d", i), d, VECS[i].src);
      chk($sformatf("R9 irq_norm v%0d", i), {31'h0, irq_norm}, {31'h0, VECS[i].np != 0});
      chk($sformatf("R9 irq_fast v%0d", i), {31'h0, irq_fast}, {31'h0, VECS[i].fp != 0});
      chk($sformatf("R6 wake v%0d", i), {31'h0, wake}, {31'h0, VECS[i].wk});
    end

    // R1: misaligned address selects nothing
    rd(8'h05, d); chk("R1 misaligned read", d, 32'h0);

    // Priority table: slot0 -> src7, slot1 -> src3, slot2 -> src9 invalid
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h1C, 32'h8000_0007);
    wr(8'h20, 32'h8000_0003);
    wr(8'h24, 32'h0000_0009);
    drive_src(32'h0000_0088);
    rd(8'h18, d); chk("R5 slot0 wins", d, 32'h8007_0000);
    drive_src(32'h0000_0008);
    rd(8'h18, d); chk("R5 slot1 when slot0 idle", d, 32'h8003_0000);
    drive_src(32'h0000_0200);
    rd(8'h18, d); chk("R4 invalid slot ignored", d, 32'h0);
    wr(8'h08, 32'h0000_0080);
    drive_src(32'h0000_0088);
    rd(8'h18, d); chk("R5 fast-routed skipped", d, 32'h8003_0000);
    chk("R3 fast out", {31'h0, irq_fast}, 32'h1);
    wr(8'h04, 32'hFFFF_FFF7);
    drive_src(32'h0000_0088);
    rd(8'h18, d); chk("R5 masked skipped", d, 32'h0);

    // R4: slot readback keeps only valid flag and source field; last slot
    wr(8'h98, 32'hFFFF_FFE0);
    rd(8'h98, d); chk("R4 slot31 readback", d, 32'h8000_0000);
    rd(8'h24, d); chk("R4 invalid slot readback", d, 32'h0000_0009);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0);
    drive_src(32'h0000_0201);
    rd(8'h18, d); chk("R5 last slot wins", d, 32'h8000_0000);

    // R10: read-only registers ignore writes
    wr(8'h10, 32'h1234_5678);
    rd(8'h10, d); chk("R10 raw write ignored", d, 32'h0000_0201);
    wr(8'h18, 32'h0);
    rd(8'h18, d); chk("R10 hp write ignored", d, 32'h8000_0000);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R10 normal view write ignored", d, 32'h0000_0201);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R10 mask untouched", d, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R10 route untouched", d, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule